// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Bank

The block controls a bank of general-purpose pins (32 by default) through a small memory-mapped register bus with 32-bit data. Each pin can be switched between input and output. Output levels are changed only through write-one-to-set and write-one-to-clear strobes, so software never needs a read-modify-write sequence. Each input is sampled through a two-flop synchronizer before it is read or used for event detection.

Every pin has its own event detector. Three separate per-pin configuration bits choose how it triggers: a method bit picks edge or level, a both-edges bit and a polarity bit refine that choice. Edge events are latched until cleared with a write-one-to-clear strobe. Level events follow the pin. A raw status view shows every detected condition. A masked view keeps only the pins that are enabled and not masked, and the OR of the masked view drives one summary interrupt line.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), `pin_out` is 0, the direction, enable and mask registers read 0, raw and masked status read 0, and `irq` is low.
- R2: The direction register at 0x08 reads back what was written and drives `pin_oe` from the next cycle on. Bit = 1 makes the pin an output.
- R3: The input register at 0x04 returns the pin levels after a two-flop synchronizer. A change on `pin_in` is visible to a read issued three cycles later.
- R4: Writing 1s to 0x10 sets those `pin_out` bits and writing 1s to 0x14 clears them. Bits written as 0 keep their level. Both offsets, and the interrupt clear at 0x30, read as 0.
- R5: With method bit (0x34) = 0 and both-edges bit (0x38) = 0, polarity bit (0x3C) = 0 latches a rising edge and 1 latches a falling edge. The opposite edge does not latch.
- R6: With method 0 and both-edges bit 1, either transition latches, whatever the polarity bit holds.
- R7: With method bit 1, raw status for the pin is 1 while the pin is high (polarity 0) or low (polarity 1). Writing the interrupt clear does not remove it while the level holds.
- R8: Writing 1s to 0x30 removes those pins' latched edge events and leaves the other pins alone. If a new edge is detected in the same cycle as its clear, the bit stays set.
- R9: Raw status (0x24) shows detected conditions regardless of enable and mask. Masked status (0x28) equals raw AND enable (0x20, 1 = enabled) AND NOT mask (0x2C, 1 = masked).
- R10: `irq` is the OR of all masked status bits.
- R11: Read data appears one cycle after `bus_rd`. Offsets that are not defined read 0. Writes to the read-only offsets (0x04, 0x24, 0x28) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| pin_out | output | NPINS | Output levels toward the pads |
| pin_oe | output | NPINS | Output enable per pin (1 = drive) |
| irq | output | 1 | Summary interrupt |

## Verification
The hardest case to reach is an edge whose detection falls in exactly the cycle in which software clears the same pin. The stimulus first leaves the pin with a latched event. It then changes the pin at a falling clock edge and counts through the two synchronizer stages, so that the clear strobe is sampled at the same rising edge that latches the new event. Raw status must still show the bit afterwards. A bench-side sweep over all eight method, both-edges and polarity combinations, each on a different pin, gives the expected raw bits for rise, clear and fall from the requirement formulas.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_INPUT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SET    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_METHOD = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_POL    = 8'h3C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_INPUT,
        SEL_DIR,
        SEL_SET,
        SEL_CLR,
        SEL_ENABLE,
        SEL_RAW,
        SEL_MSTAT,
        SEL_MASK,
        SEL_ICLR,
        SEL_METHOD,
        SEL_BOTH,
        SEL_POL
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_INPUT:  return SEL_INPUT;
            OFS_DIR:    return SEL_DIR;
            OFS_SET:    return SEL_SET;
            OFS_CLR:    return SEL_CLR;
            OFS_ENABLE: return SEL_ENABLE;
            OFS_RAW:    return SEL_RAW;
            OFS_MSTAT:  return SEL_MSTAT;
            OFS_MASK:   return SEL_MASK;
            OFS_ICLR:   return SEL_ICLR;
            OFS_METHOD: return SEL_METHOD;
            OFS_BOTH:   return SEL_BOTH;
            OFS_POL:    return SEL_POL;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    // STAGES synchronizer flops plus one history flop for edge finding
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain_d [DEPTH];
    logic [W-1:0] chain_q [DEPTH];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < DEPTH; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                chain_q[s] <= chain_d[s];
            end
        end
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

    // R3: the history flop trails the synchronized value by exactly one cycle
    assert_history_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(cur_o)));

endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] method_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] raw_o
);
    logic [W-1:0] fire_w;
    logic [W-1:0] level_w;
    logic [W-1:0] latch_d;
    logic [W-1:0] latch_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_w;
        logic fall_w;
        logic hit_w;
        assign rise_w     = cur_i[i] & ~prev_i[i];
        assign fall_w     = ~cur_i[i] & prev_i[i];
        assign hit_w      = both_i[i] ? (rise_w | fall_w)
                                      : (pol_i[i] ? fall_w : rise_w);
        assign fire_w[i]  = ~method_i[i] & hit_w;
        assign level_w[i] = cur_i[i] ^ pol_i[i];
    end

    always_comb begin
        // new edge takes priority over a clear in the same cycle
        latch_d = (latch_q & ~clr_i) | fire_w;
        raw_o   = (method_i & level_w) | (~method_i & latch_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    // R8: a latched event without a clear strobe is never lost
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(latch_q) & ~$past(clr_i) & ~latch_q) == '0));

    // R5: a detected edge is latched on the next edge, even with a clear present
    assert_edge_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire_w) |=> ((latch_q & $past(fire_w)) == $past(fire_w)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic                 irq
);
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [NPINS-1:0]  dir;
        logic [NPINS-1:0]  outv;
        logic [NPINS-1:0]  enable;
        logic [NPINS-1:0]  mask;
        logic [NPINS-1:0]  method;
        logic [NPINS-1:0]  both;
        logic [NPINS-1:0]  pol;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [NPINS-1:0] cur_w;
    logic [NPINS-1:0] prev_w;
    logic [NPINS-1:0] raw_w;
    logic [NPINS-1:0] mstat_w;
    logic [NPINS-1:0] clr_w;
    logic [NPINS-1:0] wbits_w;
    reg_sel_e         sel_w;

    function automatic logic [DATA_W-1:0] widen(input logic [NPINS-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    gpio_bank_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .cur_o   (cur_w),
        .prev_o  (prev_w)
    );

    gpio_bank_detect #(
        .W (NPINS)
    ) detect_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_i    (cur_w),
        .prev_i   (prev_w),
        .method_i (st_q.method),
        .both_i   (st_q.both),
        .pol_i    (st_q.pol),
        .clr_i    (clr_w),
        .raw_o    (raw_w)
    );

    assign sel_w   = decode_addr(bus_addr);
    assign wbits_w = bus_wdata[NPINS-1:0];
    assign clr_w   = (bus_wr && sel_w == SEL_ICLR) ? wbits_w : '0;
    assign mstat_w = raw_w & st_q.enable & ~st_q.mask;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (sel_w)
                SEL_DIR:    st_d.dir    = wbits_w;
                SEL_SET:    st_d.outv   = st_q.outv | wbits_w;
                SEL_CLR:    st_d.outv   = st_q.outv & ~wbits_w;
                SEL_ENABLE: st_d.enable = wbits_w;
                SEL_MASK:   st_d.mask   = wbits_w;
                SEL_METHOD: st_d.method = wbits_w;
                SEL_BOTH:   st_d.both   = wbits_w;
                SEL_POL:    st_d.pol    = wbits_w;
                default:    ;
            endcase
        end
        st_d.rdata = '0;
        if (bus_rd) begin
            case (sel_w)
                SEL_INPUT:  st_d.rdata = widen(cur_w);
                SEL_DIR:    st_d.rdata = widen(st_q.dir);
                SEL_ENABLE: st_d.rdata = widen(st_q.enable);
                SEL_RAW:    st_d.rdata = widen(raw_w);
                SEL_MSTAT:  st_d.rdata = widen(mstat_w);
                SEL_MASK:   st_d.rdata = widen(st_q.mask);
                SEL_METHOD: st_d.rdata = widen(st_q.method);
                SEL_BOTH:   st_d.rdata = widen(st_q.both);
                SEL_POL:    st_d.rdata = widen(st_q.pol);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign pin_out   = st_q.outv;
    assign pin_oe    = st_q.dir;
    assign irq       = |mstat_w;

    // R4: set strobe raises every written bit
    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SET) |=>
        ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R4: clear strobe lowers every written bit
    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLR) |=>
        ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

    // R4: bits written as 0 keep their output level
    assert_keep_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |=>
        (((pin_out ^ $past(pin_out)) & ~$past(bus_wdata[NPINS-1:0])) == '0));

    // R2: output enable follows a direction write
    assert_dir_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

    // R11: undefined and strobe-only offsets read as zero
    assert_zero_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (decode_addr(bus_addr) == SEL_NONE || bus_addr == OFS_SET ||
                    bus_addr == OFS_CLR || bus_addr == OFS_ICLR)) |=> (bus_rdata == '0));

    // R10: no pin enabled and unmasked means no summary interrupt
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.enable & ~st_q.mask) == '0) |-> !irq);

endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    gpio_bank #(.NPINS(NP)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", pin_oe, 32'h0);
        check("R1 out", pin_out, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h08, v); check("R1 dir", v, 32'h0);
        rd(8'h20, v); check("R1 enable", v, 32'h0);
        rd(8'h24, v); check("R1 raw", v, 32'h0);
        rd(8'h28, v); check("R1 masked", v, 32'h0);

        // R2: direction
        wr(8'h08, 32'h1234_5678);
        check("R2 oe", pin_oe, 32'h1234_5678);
        rd(8'h08, v); check("R2 readback", v, 32'h1234_5678);

        // R3: walking one through the input register
        for (int i = 0; i < NP; i++) begin
            pin_in = 32'h1 << i;
            repeat (3) @(negedge clk);
            rd(8'h04, v); check("R3 walk", v, 32'h1 << i);
        end
        pin_in = 32'hA5C3_0FF0;
        repeat (3) @(negedge clk);
        rd(8'h04, v); check("R3 pattern", v, 32'hA5C3_0FF0);
        pin_in = '0;
        settle();

        // R4: set / clear strobes
        wr(8'h10, 32'hF0F0_F0F0); check("R4 set", pin_out, 32'hF0F0_F0F0);
        wr(8'h10, 32'h0000_000F); check("R4 set keep", pin_out, 32'hF0F0_F0FF);
        wr(8'h14, 32'h0000_00F0); check("R4 clear", pin_out, 32'hF0F0_F00F);
        wr(8'h14, 32'h0000_0000); check("R4 clear zero", pin_out, 32'hF0F0_F00F);
        rd(8'h10, v); check("R4 set reads 0", v, 32'h0);
        rd(8'h14, v); check("R4 clear reads 0", v, 32'h0);
        rd(8'h30, v); check("R4 iclr reads 0", v, 32'h0);

        // R11: undefined offsets and read-only writes
        rd(8'h00, v); check("R11 undef 00", v, 32'h0);
        rd(8'h0C, v); check("R11 undef 0C", v, 32'h0);
        rd(8'h40, v); check("R11 undef 40", v, 32'h0);
        rd(8'hFC, v); check("R11 undef FC", v, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h24, v); check("R11 raw write ignored", v, 32'h0);
        rd(8'h04, v); check("R11 input write ignored", v, 32'h0);

        // R5 R6 R7 R8: sweep over all trigger combinations
        for (int c = 0; c < 8; c++) begin
            int p;
            logic m, b, pl;
            string tag;
            p  = c * 3 + 2;
            m  = c[2]; b = c[1]; pl = c[0];
            tag = m ? "R7" : (b ? "R6" : "R5");
            pin_in = '0;
            settle();
            wr(8'h34, 32'h0); wr(8'h38, 32'h0); wr(8'h3C, 32'h0);
            wr(8'h30, 32'hFFFF_FFFF);
            wr(8'h34, {31'b0, m} << p);
            wr(8'h38, {31'b0, b} << p);
            wr(8'h3C, {31'b0, pl} << p);
            settle();
            rd(8'h24, v); check({tag, " idle-low"}, v, {31'b0, m & pl} << p);
            pin_in[p] = 1'b1;
            settle();
            e = {31'b0, m ? ~pl : (b | ~pl)} << p;
            rd(8'h24, v); check({tag, " rise"}, v, e);
            wr(8'h30, 32'h1 << p);
            rd(8'h24, v); check(m ? "R7 clear held" : "R8 clear", v, {31'b0, m & ~pl} << p);
            pin_in[p] = 1'b0;
            settle();
            e = {31'b0, m ? pl : (b | pl)} << p;
            rd(8'h24, v); check({tag, " fall"}, v, e);
        end
        wr(8'h34, 32'h0); wr(8'h38, 32'h0); wr(8'h3C, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        settle();

        // R8: clear touches only written bits
        pin_in = 32'h0000_0300;
        settle();
        wr(8'h30, 32'h0000_0100);
        rd(8'h24, v); check("R8 partial clear", v, 32'h0000_0200);

        // R9 R10: enable / mask combinations on a latched pin 9
        for (int k = 0; k < 4; k++) begin
            logic en, mk;
            en = k[0]; mk = k[1];
            wr(8'h20, {31'b0, en} << 9);
            wr(8'h2C, {31'b0, mk} << 9);
            rd(8'h24, v); check("R9 raw ignores gating", v, 32'h0000_0200);
            rd(8'h28, v); check("R9 masked", v, {31'b0, en & ~mk} << 9);
            check("R10 irq", {31'b0, irq}, {31'b0, en & ~mk});
        end
        wr(8'h20, 32'hFFFF_FFFF); wr(8'h2C, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        check("R10 irq after clear", {31'b0, irq}, 32'h0);
        pin_in = '0;
        settle();
        wr(8'h30, 32'hFFFF_FFFF);

        // R8: edge detected in the same cycle as its clear stays set
        pin_in[5] = 1'b1;
        settle();
        pin_in[5] = 1'b0;
        settle();
        rd(8'h24, v); check("R8 pre-latched", v, 32'h0000_0020);
        @(negedge clk);
        pin_in[5] = 1'b1;          // sampled at next edge (stage 1)
        @(negedge clk);            // stage 2 next
        @(negedge clk);            // edge visible now, latched at next rising edge
        bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0000_0020;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(8'h24, v); check("R8 edge beats clear", v, 32'h0000_0020);
        check("R10 irq on collision", {31'b0, irq}, 32'h1);
        wr(8'h30, 32'h0000_0020);
        rd(8'h24, v); check("R8 plain clear", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule